// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped controller for general-purpose pins. The pins are grouped into banks of 32. Each bank has a direction register and an output latch. The latch can be replaced by a direct write, or it can be changed bit by bit through a set port and a clear port. Each bank also has an input register that shows the pad levels after a two-flop synchroniser.

A single-cycle register bus carries every access. On each clock edge where the write enable is high, the addressed register takes the write data. Read data is a combinational function of the address, so it is valid in the same cycle. Each pad gets an output enable, an output level and an input.

Bank `b` starts at byte offset `0x10 + 0x28*b`. Its ten 32-bit words follow at 4-byte steps. The last five words of each bank belong to an interrupt function that this block does not implement. Those words read as zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 and every output latch bit is 0. So `pad_oe` and `pad_out` are all zero, and each direction word reads `0xFFFFFFFF`.
- R2: The register group of bank `b` starts at byte offset `0x10 + 0x28*b`, for `b` = 0 to 4. Inside the group, the word at step 0 is direction, step 1 is output data, step 2 is set, step 3 is clear and step 4 is input. Steps 5 to 9 are interrupt words.
- R3: A write to a direction word replaces it, and the word reads back as written. A direction bit of 1 means input and 0 means output, and `pad_oe` for each pin is the inverse of its direction bit.
- R4: A write to the output-data word replaces the bank's latch. `pad_out` for each pin equals its latch bit from the next clock on.
- R5: A write to the set word turns on every latch bit whose write-data bit is 1 and leaves all other latch bits as they were.
- R6: A write to the clear word turns off every latch bit whose write-data bit is 1 and leaves all other latch bits as they were.
- R7: A read of the set word or of the clear word returns the current latch of that bank.
- R8: The input word shows `pad_in` through two register stages, so it lags the pad by two clock edges. This holds whatever the pin's direction.
- R9: The interrupt words (steps 5 to 9 of each group) read as zero, and writes to them change no pad output.
- R10: An access reads zero and a write changes no pad output when the address is any of the following: below `0x10`, above the last group, or not a multiple of 4.
- R11: A write to one bank changes no direction or latch bit of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_wdata | input | BANK_W (32) | Write data |
| bus_rdata | output | BANK_W (32) | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_BANKS*BANK_W (160) | Pad input levels, asynchronous |
| pad_out | output | NUM_BANKS*BANK_W (160) | Output latch bits driven to the pads |
| pad_oe | output | NUM_BANKS*BANK_W (160) | Pad output enables, 1 drives the pad |

## Verification
The bench builds the block with its default parameters: five banks of 32 pins, an 8-bit address, a base offset of `0x10` and a stride of `0x28`. These values bring the last bank at `0xB0` within reach, along with the unmapped space after it up to `0xFF`. Bank-independence checks can then use pins far from bank 0. The stride of 40 bytes is not a power of two, so the per-bank range compares are exercised at every bank boundary, including unaligned addresses inside a group.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_OFS  = 16,
  parameter int STRIDE    = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_oe
);
  localparam int NPINS = NUM_BANKS * BANK_W;
  localparam int NREGS = STRIDE / 4;
  localparam int IDX_W = $clog2(NREGS);

  logic [NPINS-1:0] dir_q, out_q, meta_q, sync_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0] rd_part;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_OFS + b*STRIDE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_OFS + (b+1)*STRIDE);
    logic              hit;
    logic [ADDR_W:0]   off;
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] dir_r, out_r;

    assign off = {1'b0, bus_addr} - LO;
    assign idx = off[IDX_W+1:2];
    assign hit = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI) && (bus_addr[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        dir_r <= '1;
        out_r <= '0;
      end else if (bus_we && hit) begin
        case (int'(idx))
          0: dir_r <= bus_wdata;
          1: out_r <= bus_wdata;
          2: out_r <= out_r | bus_wdata;
          3: out_r <= out_r & ~bus_wdata;
          default: ;
        endcase
      end

    always_comb begin
      rd_part[b] = '0;
      if (hit)
        case (int'(idx))
          0:       rd_part[b] = dir_r;
          1, 2, 3: rd_part[b] = out_r;
          4:       rd_part[b] = sync_q[b*BANK_W +: BANK_W];
          default: rd_part[b] = '0;
        endcase
    end

    assign dir_q[b*BANK_W +: BANK_W] = dir_r;
    assign out_q[b*BANK_W +: BANK_W] = out_r;
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) bus_rdata |= rd_part[b];
  end

  assign pad_oe  = ~dir_q;
  assign pad_out = out_q;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_OFS  = 16,
  parameter int STRIDE    = 40
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [BANK_W-1:0]           bus_wdata,
  input logic [BANK_W-1:0]           bus_rdata,
  input logic [NUM_BANKS*BANK_W-1:0] pad_in,
  input logic [NUM_BANKS*BANK_W-1:0] pad_out,
  input logic [NUM_BANKS*BANK_W-1:0] pad_oe
);
  localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(BASE_OFS);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BASE_OFS + 8);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BASE_OFS + 12);
  localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(BASE_OFS + 16);
  localparam logic [ADDR_W-1:0] A_IRQ0 = ADDR_W'(BASE_OFS + 20);
  localparam logic [ADDR_W-1:0] A_END0 = ADDR_W'(BASE_OFS + STRIDE);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  p_dir_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DIR0) |-> (bus_rdata == ~pad_oe[BANK_W-1:0]));

  p_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET0) |=>
      (pad_out[BANK_W-1:0] == ($past(pad_out[BANK_W-1:0]) | $past(bus_wdata))));

  p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR0) |=>
      (pad_out[BANK_W-1:0] == ($past(pad_out[BANK_W-1:0]) & ~$past(bus_wdata))));

  p_latch_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SET0 || bus_addr == A_CLR0) |-> (bus_rdata == pad_out[BANK_W-1:0]));

  p_sync_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && bus_addr == A_IN0) |-> (bus_rdata == $past(pad_in[BANK_W-1:0], 2)));

  p_irq_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= A_IRQ0 && bus_addr < A_END0) |-> (bus_rdata == '0));

  p_low_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr < A_DIR0) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
  .BASE_OFS(BASE_OFS), .STRIDE(STRIDE)
) u_chk (.*);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [159:0] pad_in = '0;
  logic [159:0] pad_out, pad_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 oe", pad_oe, '0);
    chk("R1 out", pad_out, '0);
    rd(8'h10, d); chk("R1 dir bank0", 160'(d), 160'hFFFF_FFFF);
    rd(8'hB0, d); chk("R1 R2 dir bank4", 160'(d), 160'hFFFF_FFFF);
  endtask

  task automatic t_direction;
    logic [31:0] d;
    wr(8'h10, 32'h0000_FF00);
    rd(8'h10, d); chk("R3 dir readback", 160'(d), 160'h0000_FF00);
    chk("R3 oe inverse", 160'(pad_oe[31:0]), 160'hFFFF_00FF);
  endtask

  task automatic t_outdata;
    logic [31:0] d;
    wr(8'h14, 32'hA5A5_0F0F);
    chk("R4 pad_out", 160'(pad_out[31:0]), 160'hA5A5_0F0F);
    rd(8'h14, d); chk("R4 readback", 160'(d), 160'hA5A5_0F0F);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(8'h18, 32'hF000_0001);
    chk("R5 set", 160'(pad_out[31:0]), 160'hF5A5_0F0F);
    rd(8'h18, d); chk("R7 set view", 160'(d), 160'hF5A5_0F0F);
    wr(8'h1C, 32'h0500_0F00);
    chk("R6 clear", 160'(pad_out[31:0]), 160'hF0A5_000F);
    rd(8'h1C, d); chk("R7 clear view", 160'(d), 160'hF0A5_000F);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk);
    pad_in[31:0] = 32'h1234_5678;
    @(negedge clk);
    rd(8'h20, d); chk("R8 one edge lag", 160'(d), 160'h0);
    @(negedge clk);
    rd(8'h20, d); chk("R8 after two edges", 160'(d), 160'h1234_5678);
    pad_in[159:128] = 32'hCAFE_0001;
    repeat (2) @(negedge clk);
    rd(8'hC0, d); chk("R8 R2 bank4 input", 160'(d), 160'hCAFE_0001);
  endtask

  task automatic t_banks;
    logic [31:0] d;
    wr(8'hB4, 32'hDEAD_BEEF);
    chk("R2 R11 bank4 out", 160'(pad_out[159:128]), 160'hDEAD_BEEF);
    chk("R11 middle banks", 160'(pad_out[127:32]), 160'h0);
    chk("R11 bank0 kept", 160'(pad_out[31:0]), 160'hF0A5_000F);
    wr(8'h38, 32'h0);
    chk("R2 R3 bank1 oe", 160'(pad_oe[63:32]), 160'hFFFF_FFFF);
    chk("R11 bank2 oe", 160'(pad_oe[95:64]), 160'h0);
    rd(8'h38, d); chk("R2 bank1 dir", 160'(d), 160'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    logic [159:0] o, e;
    o = pad_out; e = pad_oe;
    for (int k = 5; k < 10; k++) wr(8'(8'h10 + 4*k), 32'hFFFF_FFFF);
    wr(8'h9C, 32'hFFFF_FFFF);
    chk("R9 out kept", pad_out, o);
    chk("R9 oe kept", pad_oe, e);
    rd(8'h24, d); chk("R9 irq read", 160'(d), 160'h0);
    rd(8'h34, d); chk("R9 irq status read", 160'(d), 160'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [159:0] o, e;
    o = pad_out; e = pad_oe;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h15, 32'hFFFF_FFFF);
    wr(8'hD8, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    chk("R10 out kept", pad_out, o);
    chk("R10 oe kept", pad_oe, e);
    rd(8'h0C, d); chk("R10 low read", 160'(d), 160'h0);
    rd(8'h15, d); chk("R10 unaligned read", 160'(d), 160'h0);
    rd(8'hD8, d); chk("R10 past end read", 160'(d), 160'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_outdata();
    t_setclr();
    t_input();
    t_banks();
    t_irq();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule